// File: doc/BRIEF.md
# Capability Access Authorisation Checker

This block decides, in a single combinational pass, whether one memory or control-flow access is permitted by a capability whose fields are already decoded. It receives the capability's tag, sealed flag, three permission bits, base address and a top bound one bit wider than the address. It also receives the kind of access, the address, the access size in bytes and a flag raised elsewhere when the address is not valid. When the access is refused it reports one fault with a fault class, a cause code, the exception code and a trap value.

Four kinds of access are judged: instruction fetch, data load, data store and control-transfer target. A target check can be for a direct transfer (branch or relative jump), which only needs the target inside bounds and a valid address. It can also be for an indirect jump, which also looks at the target capability's tag, execute permission and seal together with the immediate offset. When several rules are broken at once, a fixed priority picks the reported cause, so the trap handler always sees one reason.

Top module: `cap_access_guard`

## Requirements
- R1: A fetch (acc_kind=0) faults if the tag is clear, the capability is sealed, execute permission (cap_perm[2]) is clear, or any byte of the acc_size-byte instruction is out of bounds. Its fault class is 0.
- R2: A load (acc_kind=1) or store (acc_kind=2) faults if the tag is clear, the capability is sealed, or any accessed byte is out of bounds. A load also faults without read permission (cap_perm[0]) and a store without write permission (cap_perm[1]). The fault class is 1.
- R3: A direct target (acc_kind=3, tgt_indirect=0) checks only the invalid-address flag and the bounds of a minimum-sized instruction at the target. Tag, seal and permissions are ignored. The fault class is 2.
- R4: An indirect target (acc_kind=3, tgt_indirect=1) also faults on a clear tag or missing execute permission. It faults on a sealed capability only when tgt_imm_nz is high; a sealed capability with a zero immediate is accepted. The fault class is 2.
- R5: An access is in bounds only when cap_base ≤ acc_addr and acc_addr + size ≤ cap_top, both compared in a width wider than the address, so the sum never wraps. A top above 2^ADDR_W is honoured as given.
- R6: The minimum instruction size used for targets is 2 bytes when COMPRESSED=1 and 4 bytes when COMPRESSED=0.
- R7: When several rules fail, fault_cause reports the first in this order: tag=0, seal=1, permission=2, invalid address=3, bounds=4. Any raised addr_invalid counts as a fault for every kind.
- R8: exc_code is 28 whenever fault_valid is high, and 0 otherwise.
- R9: trap_value equals acc_addr for a load or store fault, and is 0 in every other case.
- R10: With no failing rule, fault_valid is low and fault_type, fault_cause, exc_code and trap_value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_tag | input | 1 | Capability tag bit |
| cap_sealed | input | 1 | Capability is sealed |
| cap_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| cap_base | input | ADDR_W | Decoded lower bound |
| cap_top | input | ADDR_W+1 | Decoded upper bound (exclusive), not wrapping |
| addr_invalid | input | 1 | Address flagged invalid by the caller |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 transfer target |
| tgt_indirect | input | 1 | Target comes from an indirect jump |
| tgt_imm_nz | input | 1 | Indirect jump immediate is non-zero |
| acc_addr | input | ADDR_W | Access or target address |
| acc_size | input | SIZE_W | Bytes accessed for fetch, load, store |
| fault_valid | output | 1 | Access refused |
| fault_type | output | 2 | Fault class: 0 fetch, 1 data, 2 target |
| fault_cause | output | 4 | Highest-priority cause code |
| exc_code | output | 6 | Exception code |
| trap_value | output | ADDR_W | Faulting data address or 0 |

## Verification
The bench runs with an 8-bit address so that every address and access size can be swept against bound pairs that include a top beyond the address range. It uses degenerate cases, a window near the top and a tight window in the middle. These sweeps separate a wrapping comparison from a wide one and show whether the last byte is counted correctly. A second sweep fixes the geometry and steps through every combination of tag, seal, permission, invalid flag and immediate for each access kind. That sweep shows whether each kind uses its own rule set and whether the priority encoder picks the right cause. Two instances that differ only in the compressed setting tell the two minimum target sizes apart.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;
  localparam int TYPE_W  = 2;
  localparam int CAUSE_W = 4;
  localparam int EXC_W   = 6;
  localparam int N_RULES = 5;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_STORE  = 2'd2,
    ACC_TARGET = 2'd3
  } acc_kind_e;

  localparam logic [TYPE_W-1:0] FCLASS_FETCH  = 2'd0;
  localparam logic [TYPE_W-1:0] FCLASS_DATA   = 2'd1;
  localparam logic [TYPE_W-1:0] FCLASS_TARGET = 2'd2;

  localparam logic [EXC_W-1:0] EXC_CAP_FAULT = 6'd28;

  // bit index equals the reported cause code (lower index wins)
  typedef struct packed {
    logic bounds;   // 4
    logic inval;    // 3
    logic perm;     // 2
    logic seal;     // 1
    logic tag;      // 0
  } viol_t;
endpackage

// File: rtl/cap_bound_eval.sv
module cap_bound_eval #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   top,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              in_bounds
);
  localparam int WIDE_W = ADDR_W + 2;

  function automatic logic lower_ok(input logic [ADDR_W-1:0] b,
                                    input logic [ADDR_W-1:0] a);
    return b <= a;
  endfunction

  function automatic logic upper_ok(input logic [ADDR_W-1:0] a,
                                    input logic [SIZE_W-1:0] s,
                                    input logic [ADDR_W:0]   t);
    logic [WIDE_W-1:0] past_end;
    past_end = WIDE_W'(a) + WIDE_W'(s);
    return past_end <= WIDE_W'(t);
  endfunction

  logic low_pass, high_pass;
  assign low_pass  = lower_ok(base, addr);
  assign high_pass = upper_ok(addr, size, top);
  assign in_bounds = low_pass & high_pass;

  always_comb begin
    assert_base_below_addr_R5: assert (!in_bounds || ({1'b0, base} <= {1'b0, addr}))
      else $error("in_bounds with base above address");
  end
endmodule

// File: rtl/cap_rule_eval.sv
module cap_rule_eval
  import cap_guard_pkg::*;
(
  input  logic       tag,
  input  logic       sealed,
  input  logic [2:0] perm,
  input  logic       addr_invalid,
  input  acc_kind_e  kind,
  input  logic       tgt_indirect,
  input  logic       tgt_imm_nz,
  input  logic       in_bounds,
  output viol_t      viol
);
  always_comb begin
    viol        = '0;
    viol.inval  = addr_invalid;
    viol.bounds = !in_bounds;
    unique case (kind)
      ACC_FETCH: begin
        viol.tag  = !tag;
        viol.seal = sealed;
        viol.perm = !perm[2];
      end
      ACC_LOAD: begin
        viol.tag  = !tag;
        viol.seal = sealed;
        viol.perm = !perm[0];
      end
      ACC_STORE: begin
        viol.tag  = !tag;
        viol.seal = sealed;
        viol.perm = !perm[1];
      end
      ACC_TARGET: begin
        if (tgt_indirect) begin
          viol.tag  = !tag;
          viol.seal = sealed & tgt_imm_nz;
          viol.perm = !perm[2];
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_direct_ignores_cap_R3: assert (!(kind == ACC_TARGET && !tgt_indirect) ||
                                          !(viol.tag | viol.seal | viol.perm))
      else $error("direct target flagged tag/seal/perm");
    assert_sentry_zero_imm_R4: assert (!(kind == ACC_TARGET && !tgt_imm_nz) || !viol.seal)
      else $error("seal fault on zero-immediate target");
  end
endmodule

// File: rtl/cap_fault_pick.sv
module cap_fault_pick
  import cap_guard_pkg::*;
(
  input  viol_t               viol,
  input  acc_kind_e           kind,
  output logic                fault_valid,
  output logic [TYPE_W-1:0]   fault_type,
  output logic [CAUSE_W-1:0]  fault_cause
);
  logic [N_RULES-1:0] flags;
  assign flags = viol;

  always_comb begin
    fault_cause = '0;
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (flags[i]) fault_cause = CAUSE_W'(i);
    end
  end

  assign fault_valid = |flags;

  always_comb begin
    fault_type = '0;
    if (fault_valid) begin
      unique case (kind)
        ACC_FETCH:  fault_type = FCLASS_FETCH;
        ACC_TARGET: fault_type = FCLASS_TARGET;
        default:    fault_type = FCLASS_DATA;
      endcase
    end
  end

  always_comb begin
    assert_cause_range_R7: assert (fault_cause < CAUSE_W'(N_RULES))
      else $error("reserved cause reported");
    assert_cause_is_first_R7: assert (!fault_valid || $countones(flags & ((N_RULES'(1) << fault_cause) - N_RULES'(1))) == 0)
      else $error("lower-ranked cause chosen over higher one");
    assert_quiet_when_clear_R10: assert (fault_valid || (fault_type == '0 && fault_cause == '0))
      else $error("fields nonzero without fault");
  end
endmodule

// File: rtl/cap_access_guard.sv
module cap_access_guard
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 4,
  parameter bit COMPRESSED = 1'b1
) (
  input  logic                cap_tag,
  input  logic                cap_sealed,
  input  logic [2:0]          cap_perm,
  input  logic [ADDR_W-1:0]   cap_base,
  input  logic [ADDR_W:0]     cap_top,
  input  logic                addr_invalid,
  input  logic [1:0]          acc_kind,
  input  logic                tgt_indirect,
  input  logic                tgt_imm_nz,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [SIZE_W-1:0]   acc_size,
  output logic                fault_valid,
  output logic [TYPE_W-1:0]   fault_type,
  output logic [CAUSE_W-1:0]  fault_cause,
  output logic [EXC_W-1:0]    exc_code,
  output logic [ADDR_W-1:0]   trap_value
);
  localparam int MIN_INSN = COMPRESSED ? 2 : 4;

  acc_kind_e   kind;
  logic [SIZE_W-1:0] span;
  logic        in_bounds;
  viol_t       viol;
  logic        data_kind;

  assign kind      = acc_kind_e'(acc_kind);
  assign data_kind = (kind == ACC_LOAD) || (kind == ACC_STORE);
  assign span      = (kind == ACC_TARGET) ? SIZE_W'(MIN_INSN) : acc_size;

  cap_bound_eval #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bounds (
    .base      (cap_base),
    .top       (cap_top),
    .addr      (acc_addr),
    .size      (span),
    .in_bounds (in_bounds)
  );

  cap_rule_eval u_rules (
    .tag          (cap_tag),
    .sealed       (cap_sealed),
    .perm         (cap_perm),
    .addr_invalid (addr_invalid),
    .kind         (kind),
    .tgt_indirect (tgt_indirect),
    .tgt_imm_nz   (tgt_imm_nz),
    .in_bounds    (in_bounds),
    .viol         (viol)
  );

  cap_fault_pick u_pick (
    .viol        (viol),
    .kind        (kind),
    .fault_valid (fault_valid),
    .fault_type  (fault_type),
    .fault_cause (fault_cause)
  );

  assign exc_code   = fault_valid ? EXC_CAP_FAULT : '0;
  assign trap_value = (fault_valid && data_kind) ? acc_addr : '0;

  always_comb begin
    assert_exc_tracks_fault_R8: assert ((exc_code == EXC_CAP_FAULT) == fault_valid)
      else $error("exception code disagrees with fault");
    assert_trap_only_data_R9: assert (trap_value == '0 || (data_kind && fault_valid))
      else $error("trap value on non-data fault");
    assert_clean_pass_R10: assert (fault_valid || (exc_code == '0 && trap_value == '0))
      else $error("outputs nonzero without fault");
  end
endmodule

// File: tb/cap_access_guard_bench.sv
module cap_access_guard_bench;
  localparam int AW = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          tag, sealed, inval, ind, immnz;
  logic [2:0]    perm;
  logic [AW-1:0] base, addr;
  logic [AW:0]   top;
  logic [1:0]    kind;
  logic [SW-1:0] size;

  logic          v_c, v_n;
  logic [1:0]    ty_c, ty_n;
  logic [3:0]    ca_c, ca_n;
  logic [5:0]    ex_c, ex_n;
  logic [AW-1:0] tr_c, tr_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  cap_access_guard #(.ADDR_W(AW), .SIZE_W(SW), .COMPRESSED(1'b1)) u_cap_access_guard (
    .cap_tag(tag), .cap_sealed(sealed), .cap_perm(perm), .cap_base(base), .cap_top(top),
    .addr_invalid(inval), .acc_kind(kind), .tgt_indirect(ind), .tgt_imm_nz(immnz),
    .acc_addr(addr), .acc_size(size), .fault_valid(v_c), .fault_type(ty_c),
    .fault_cause(ca_c), .exc_code(ex_c), .trap_value(tr_c));

  cap_access_guard #(.ADDR_W(AW), .SIZE_W(SW), .COMPRESSED(1'b0)) u_cap_access_guard_nc (
    .cap_tag(tag), .cap_sealed(sealed), .cap_perm(perm), .cap_base(base), .cap_top(top),
    .addr_invalid(inval), .acc_kind(kind), .tgt_indirect(ind), .tgt_imm_nz(immnz),
    .acc_addr(addr), .acc_size(size), .fault_valid(v_n), .fault_type(ty_n),
    .fault_cause(ca_n), .exc_code(ex_n), .trap_value(tr_n));

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent reference built from the requirement text
  task automatic model(input int comp, output int v, output int ty, output int ca,
                       output int ex, output int tr);
    int  sz;
    bit  inb, vt, vs, vp, vi, vb;
    sz  = (kind == 3) ? (comp ? 2 : 4) : int'(size);
    inb = (int'(base) <= int'(addr)) && (int'(addr) + sz <= int'(top));
    vt = 0; vs = 0; vp = 0;
    case (kind)
      2'd0: begin vt = !tag; vs = sealed; vp = !perm[2]; end
      2'd1: begin vt = !tag; vs = sealed; vp = !perm[0]; end
      2'd2: begin vt = !tag; vs = sealed; vp = !perm[1]; end
      default: if (ind) begin vt = !tag; vs = sealed && immnz; vp = !perm[2]; end
    endcase
    vi = inval;
    vb = !inb;
    v  = int'(vt | vs | vp | vi | vb);
    ca = vt ? 0 : vs ? 1 : vp ? 2 : vi ? 3 : vb ? 4 : 0;
    ty = !v ? 0 : (kind == 0) ? 0 : (kind == 3) ? 2 : 1;
    ex = v ? 28 : 0;
    tr = (v && (kind == 1 || kind == 2)) ? int'(addr) : 0;
  endtask

  task automatic check_vec(input string vreq);
    int v, ty, ca, ex, tr;
    @(negedge clk);
    model(1, v, ty, ca, ex, tr);
    cmp(vreq, "valid", int'(v_c), v);
    cmp(v ? vreq : "R10", "class", int'(ty_c), ty);
    cmp(v ? "R7" : "R10", "cause", int'(ca_c), ca);
    cmp("R8", "exc", int'(ex_c), ex);
    cmp("R9", "trap", int'(tr_c), tr);
    model(0, v, ty, ca, ex, tr);
    cmp((kind == 3) ? "R6" : vreq, "valid_nc", int'(v_n), v);
    cmp(v ? "R7" : "R10", "cause_nc", int'(ca_n), ca);
  endtask

  task automatic drive_flags(input int bits);
    tag = bits[0]; sealed = bits[1]; perm = 3'(bits >> 2);
    inval = bits[5]; immnz = bits[6];
  endtask

  function automatic string kind_req(input int k, input int i);
    if (k == 0) return "R1";
    if (k == 3) return i ? "R4" : "R3";
    return "R2";
  endfunction

  initial begin
    tag = 0; sealed = 0; perm = 0; inval = 0; ind = 0; immnz = 0;
    base = 0; top = 0; addr = 0; size = 0; kind = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: clean first access with every output at zero
    @(posedge clk);
    tag = 1; perm = 3'b111; base = 8'd0; top = 9'd256; addr = 8'd40; size = 3'd4; kind = 2'd1;
    check_vec("R10");

    // rule-set and priority sweep with a fixed in-bounds geometry (R1 R2 R3 R4 R7)
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 2; i++) begin
        for (int b = 0; b < 128; b++) begin
          @(posedge clk);
          kind = 2'(k); ind = i[0]; drive_flags(b);
          base = 8'd16; top = 9'd64; addr = 8'd32; size = 3'd4;
          check_vec(kind_req(k, i));
        end
      end
    end

    // geometry sweep with all permissions granted (R5 R6 R9)
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 256; a++) begin
          for (int s = 0; s < 8; s++) begin
            @(posedge clk);
            drive_flags(7'b0011101);
            ind = 1'b0; kind = 2'(k); addr = 8'(a); size = 3'(s);
            case (p)
              0: begin base = 8'd0;   top = 9'd256; end
              1: begin base = 8'd250; top = 9'd257; end
              2: begin base = 8'd100; top = 9'd108; end
              default: begin base = 8'd200; top = 9'd100; end
            endcase
            check_vec("R5");
          end
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule